// File: doc/BRIEF.md
# Boundary-Scan Test Port with Self-Test Launch

This block is a four-wire serial test port for a chip. It contains the sixteen-state test controller, a four-bit instruction register and four data registers: a one-bit pass-through register, an optional 32-bit identification register, a short chain of boundary cells and a two-bit self-test result register. The boundary chain sits between the chip pads and the core. Depending on the active instruction, it is either transparent, or it drives the pads or the core from its update stage.

A dedicated instruction raises a start level to the core's self-test engine. That engine runs on the system clock. Its done and pass flags come back asynchronously and are synchronised into the test clock domain. They can then be read in two places: through the result register, and in the status bits that the instruction register captures. All state advances on the rising edge of `tck`. The serial output changes on the falling edge.

Top module: `tap_bist_ctrl`

## Requirements
- R1: The controller follows the standard sixteen-state transition graph on each rising `tck` edge. From Test-Logic-Reset, a low `tms` moves it to Run-Test/Idle.
- R2: Five consecutive rising edges with `tms` high always reach Test-Logic-Reset. Holding `tap_rst` high, which is synchronous and active-high, forces Test-Logic-Reset as well.
- R3: In Test-Logic-Reset the active instruction becomes IDCODE, or BYPASS when `HAS_ID` is 0. In that state the pads and the core are connected straight through: `pin_out`=`core_out`, `pin_oe`=`core_oe`, `core_in`=`pin_in`, `pin_bi_o`=`core_bi_o` and `core_bi_i`=`pin_bi_i`.
- R4: The instruction register shifts LSB first. Capture-IR loads bit0=1 and bit1=0, plus bit2=synchronised BIST done and bit3=synchronised BIST pass.
- R5: `tdo` and `tdo_en` change on the falling edge of `tck`. `tdo_en` is high only while the controller is in Shift-DR or Shift-IR.
- R6: The instruction codes are EXTEST=0000, SAMPLE/PRELOAD=0001, IDCODE=0010, INTEST=0011, RUNBIST=0100 and BYPASS=1111. Every other code selects the pass-through register.
- R7: The pass-through register is one bit wide and captures 0. While shifting, `tdo` therefore shows 0 and then `tdi` delayed by one bit.
- R8: IDCODE shifts out the 32-bit `ID_VALUE`, LSB first.
- R9: The boundary chain is ordered from `tdo` to `tdi` as follows: input cells (index 0..NIN-1), bidirectional cells, output cells, the output-enable cell, then the sample-only cell. Input, bidirectional and sample-only cells capture the pad side. Output and enable cells capture the core side.
- R10: Under EXTEST, `pin_out`, `pin_bi_o` and `pin_oe` come from the update stage, and the core still sees the pads.
- R11: Under INTEST, `core_in` and `core_bi_i` come from the update stage and ignore the pads. The pads stay driven from the update stage.
- R12: SAMPLE/PRELOAD captures and loads the update stage without changing any pad or core signal. The sample-only cell has no update stage.
- R13: `bist_start` is high exactly while RUNBIST is active, starting from its Update-IR. Under RUNBIST the pads are driven from the update stage. The two-bit result register captures bit0=done and bit1=pass, taken after a two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tap_rst | input | 1 | Synchronous active-high test reset |
| tms | input | 1 | Mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, falling-edge timed |
| tdo_en | output | 1 | High when `tdo` is driven |
| pin_in | input | NIN | Input pads |
| core_in | output | NIN | Input values to the core |
| pin_bi_i | input | NBI | Bidirectional pad read value |
| pin_bi_o | output | NBI | Bidirectional pad drive value |
| core_bi_o | input | NBI | Core drive value for bidirectional pads |
| core_bi_i | output | NBI | Bidirectional value seen by the core |
| core_out | input | NOUT | Core output values |
| pin_out | output | NOUT | Output pads |
| core_oe | input | 1 | Core output enable |
| pin_oe | output | 1 | Pad output enable |
| pin_obs | input | 1 | Observe-only pad |
| bist_start | output | 1 | Self-test start level |
| bist_done | input | 1 | Self-test done, system clock domain |
| bist_pass | input | 1 | Self-test pass, system clock domain |

## Verification
The hardest situation to reach from the ports is RUNBIST reporting separate done and pass values. The flags are asynchronous, and they are visible only after synchronisation and a capture. The stimulus therefore works in stages. It first loads RUNBIST. It then raises done with pass still low and idles the controller for several clocks before reading the result register. Next it raises pass and reads again. Finally it leaves through an instruction scan, whose captured status bits must show both flags. A second instance built without an identification register shares the serial inputs, so that the IDCODE fallback to pass-through is observed on the same scans.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    localparam int IR_W = 4;

    localparam logic [IR_W-1:0] OP_EXTEST  = 4'h0;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 4'h1;
    localparam logic [IR_W-1:0] OP_IDCODE  = 4'h2;
    localparam logic [IR_W-1:0] OP_INTEST  = 4'h3;
    localparam logic [IR_W-1:0] OP_RUNBIST = 4'h4;
    localparam logic [IR_W-1:0] OP_BYPASS  = 4'hF;

    typedef enum logic [3:0] {
        ST_TLR, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_t;

    typedef enum logic [1:0] {DR_BYP, DR_ID, DR_BSR, DR_BIST} dr_sel_t;

    typedef struct packed {
        dr_sel_t sel;
        logic    pads_from_upd;
        logic    core_from_upd;
        logic    bist_go;
    } ir_dec_t;

    function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
        case (s)
            ST_TLR:    return m ? ST_TLR    : ST_IDLE;
            ST_IDLE:   return m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: return m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
            default:   return m ? ST_SEL_DR : ST_IDLE;
        endcase
    endfunction

    function automatic ir_dec_t ir_decode(input logic [IR_W-1:0] c, input bit has_id);
        ir_dec_t d;
        d.sel           = DR_BYP;
        d.pads_from_upd = 1'b0;
        d.core_from_upd = 1'b0;
        d.bist_go       = 1'b0;
        case (c)
            OP_EXTEST:  begin d.sel = DR_BSR; d.pads_from_upd = 1'b1; end
            OP_SAMPLE:  d.sel = DR_BSR;
            OP_IDCODE:  d.sel = has_id ? DR_ID : DR_BYP;
            OP_INTEST:  begin d.sel = DR_BSR; d.pads_from_upd = 1'b1; d.core_from_upd = 1'b1; end
            OP_RUNBIST: begin d.sel = DR_BIST; d.pads_from_upd = 1'b1; d.bist_go = 1'b1; end
            default:    d.sel = DR_BYP;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_t state
);

    always_ff @(posedge tck) begin
        if (rst) state <= ST_TLR;
        else     state <= tap_next(state, tms);
    end

    // consecutive-high counter used only by the check below
    logic [2:0] hi_cnt;
    always_ff @(posedge tck) begin
        if (rst)           hi_cnt <= '0;
        else if (!tms)     hi_cnt <= '0;
        else if (hi_cnt != 3'd5) hi_cnt <= 3'(hi_cnt + 3'd1);
    end

    assert_five_high_R2: assert property (@(posedge tck) disable iff (rst)
        hi_cnt == 3'd5 |-> state == ST_TLR);

    assert_reset_exit_R1: assert property (@(posedge tck) disable iff (rst)
        (state == ST_TLR && !tms) |=> state == ST_IDLE);

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import scan_tap_pkg::*;
#(
    parameter bit HAS_ID = 1'b1
) (
    input  logic            tck,
    input  logic            rst,
    input  tap_state_t      state,
    input  logic            tdi,
    input  logic [1:0]      status,   // {pass, done}
    output logic            ir_so,
    output logic [IR_W-1:0] instr
);

    localparam logic [IR_W-1:0] DEFAULT_OP = HAS_ID ? OP_IDCODE : OP_BYPASS;

    logic [IR_W-1:0] sr;

    always_ff @(posedge tck) begin
        if (rst) begin
            sr    <= '0;
            instr <= DEFAULT_OP;
        end else begin
            case (state)
                ST_TLR:    instr <= DEFAULT_OP;
                ST_CAP_IR: sr    <= {status, 2'b01};
                ST_SH_IR:  sr    <= {tdi, sr[IR_W-1:1]};
                ST_UPD_IR: instr <= sr;
                default:   ;
            endcase
        end
    end

    assign ir_so = sr[0];

    assert_ir_fixed_bits_R4: assert property (@(posedge tck) disable iff (rst)
        state == ST_CAP_IR |=> sr[1:0] == 2'b01);

    assert_reset_instr_R3: assert property (@(posedge tck) disable iff (rst)
        state == ST_TLR |=> instr == DEFAULT_OP);

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
    import scan_tap_pkg::*;
#(
    parameter int NIN  = 2,
    parameter int NBI  = 1,
    parameter int NOUT = 2
) (
    input  logic            tck,
    input  logic            rst,
    input  tap_state_t      state,
    input  logic            tdi,
    input  logic            sel,
    input  logic            pads_from_upd,
    input  logic            core_from_upd,
    input  logic [NIN-1:0]  pin_in,
    output logic [NIN-1:0]  core_in,
    input  logic [NBI-1:0]  pin_bi_i,
    output logic [NBI-1:0]  pin_bi_o,
    input  logic [NBI-1:0]  core_bi_o,
    output logic [NBI-1:0]  core_bi_i,
    input  logic [NOUT-1:0] core_out,
    output logic [NOUT-1:0] pin_out,
    input  logic            core_oe,
    output logic            pin_oe,
    input  logic            pin_obs,
    output logic            so
);

    localparam int B0 = NIN;
    localparam int O0 = NIN + NBI;
    localparam int EN = NIN + NBI + NOUT;
    localparam int OB = EN + 1;
    localparam int L  = OB + 1;

    logic [L-1:0] cap, sr;
    logic [L-2:0] upd;   // sample-only cell (index OB) has no update stage

    always_comb begin
        cap = '0;
        for (int i = 0; i < NIN; i++)  cap[i]      = pin_in[i];
        for (int i = 0; i < NBI; i++)  cap[B0 + i] = pin_bi_i[i];
        for (int i = 0; i < NOUT; i++) cap[O0 + i] = core_out[i];
        cap[EN] = core_oe;
        cap[OB] = pin_obs;
    end

    always_ff @(posedge tck) begin
        if (rst) begin
            sr  <= '0;
            upd <= '0;
        end else if (sel) begin
            case (state)
                ST_CAP_DR: sr  <= cap;
                ST_SH_DR:  sr  <= {tdi, sr[L-1:1]};
                ST_UPD_DR: upd <= sr[L-2:0];
                default:   ;
            endcase
        end
    end

    assign so = sr[0];

    genvar g;
    generate
        for (g = 0; g < NIN; g++) begin : g_in
            assign core_in[g] = core_from_upd ? upd[g] : pin_in[g];
        end
        for (g = 0; g < NBI; g++) begin : g_bi
            assign pin_bi_o[g]  = pads_from_upd ? upd[B0 + g] : core_bi_o[g];
            assign core_bi_i[g] = core_from_upd ? upd[B0 + g] : pin_bi_i[g];
        end
        for (g = 0; g < NOUT; g++) begin : g_out
            assign pin_out[g] = pads_from_upd ? upd[O0 + g] : core_out[g];
        end
    endgenerate

    assign pin_oe = pads_from_upd ? upd[EN] : core_oe;

    assert_upd_hold_R12: assert property (@(posedge tck) disable iff (rst)
        !(sel && state == ST_UPD_DR) |=> $stable(upd));

endmodule

// File: rtl/tap_bist_ctrl.sv
module tap_bist_ctrl
    import scan_tap_pkg::*;
#(
    parameter int          NIN      = 2,
    parameter int          NBI      = 1,
    parameter int          NOUT     = 2,
    parameter bit          HAS_ID   = 1'b1,
    parameter logic [31:0] ID_VALUE = 32'h1A5B_C0DF
) (
    input  logic            tck,
    input  logic            tap_rst,
    input  logic            tms,
    input  logic            tdi,
    output logic            tdo,
    output logic            tdo_en,
    input  logic [NIN-1:0]  pin_in,
    output logic [NIN-1:0]  core_in,
    input  logic [NBI-1:0]  pin_bi_i,
    output logic [NBI-1:0]  pin_bi_o,
    input  logic [NBI-1:0]  core_bi_o,
    output logic [NBI-1:0]  core_bi_i,
    input  logic [NOUT-1:0] core_out,
    output logic [NOUT-1:0] pin_out,
    input  logic            core_oe,
    output logic            pin_oe,
    input  logic            pin_obs,
    output logic            bist_start,
    input  logic            bist_done,
    input  logic            bist_pass
);

    localparam int ID_W = 32;

    tap_state_t      state;
    logic [IR_W-1:0] instr;
    ir_dec_t         dec;
    logic            ir_so, bsr_so, id_so, dr_so;
    logic [1:0]      flag_s1, flag_s2;   // {pass, done}
    logic            byp_q;
    logic [1:0]      bres;

    // two-flop synchroniser from the system clock domain
    always_ff @(posedge tck) begin
        if (tap_rst) begin
            flag_s1 <= '0;
            flag_s2 <= '0;
        end else begin
            flag_s1 <= {bist_pass, bist_done};
            flag_s2 <= flag_s1;
        end
    end

    tap_fsm u_fsm (
        .tck   (tck),
        .rst   (tap_rst),
        .tms   (tms),
        .state (state)
    );

    tap_ir #(.HAS_ID(HAS_ID)) u_ir (
        .tck    (tck),
        .rst    (tap_rst),
        .state  (state),
        .tdi    (tdi),
        .status (flag_s2),
        .ir_so  (ir_so),
        .instr  (instr)
    );

    assign dec        = ir_decode(instr, HAS_ID);
    assign bist_start = dec.bist_go;

    bscan_chain #(.NIN(NIN), .NBI(NBI), .NOUT(NOUT)) u_bsr (
        .tck           (tck),
        .rst           (tap_rst),
        .state         (state),
        .tdi           (tdi),
        .sel           (dec.sel == DR_BSR),
        .pads_from_upd (dec.pads_from_upd),
        .core_from_upd (dec.core_from_upd),
        .pin_in        (pin_in),
        .core_in       (core_in),
        .pin_bi_i      (pin_bi_i),
        .pin_bi_o      (pin_bi_o),
        .core_bi_o     (core_bi_o),
        .core_bi_i     (core_bi_i),
        .core_out      (core_out),
        .pin_out       (pin_out),
        .core_oe       (core_oe),
        .pin_oe        (pin_oe),
        .pin_obs       (pin_obs),
        .so            (bsr_so)
    );

    // pass-through and self-test result registers
    always_ff @(posedge tck) begin
        if (tap_rst) begin
            byp_q <= 1'b0;
            bres  <= '0;
        end else begin
            if (dec.sel == DR_BYP) begin
                if (state == ST_CAP_DR)     byp_q <= 1'b0;
                else if (state == ST_SH_DR) byp_q <= tdi;
            end
            if (dec.sel == DR_BIST) begin
                if (state == ST_CAP_DR)     bres <= flag_s2;
                else if (state == ST_SH_DR) bres <= {tdi, bres[1]};
            end
        end
    end

    generate
        if (HAS_ID) begin : g_id
            logic [ID_W-1:0] idr;
            always_ff @(posedge tck) begin
                if (tap_rst) idr <= '0;
                else if (dec.sel == DR_ID) begin
                    if (state == ST_CAP_DR)     idr <= ID_VALUE;
                    else if (state == ST_SH_DR) idr <= {tdi, idr[ID_W-1:1]};
                end
            end
            assign id_so = idr[0];
        end else begin : g_no_id
            assign id_so = 1'b0;
        end
    endgenerate

    always_comb begin
        case (dec.sel)
            DR_ID:   dr_so = id_so;
            DR_BSR:  dr_so = bsr_so;
            DR_BIST: dr_so = bres[0];
            default: dr_so = byp_q;
        endcase
    end

    // serial output retimed to the falling edge
    always_ff @(negedge tck) begin
        if (tap_rst) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= (state == ST_SH_DR) || (state == ST_SH_IR);
            if (state == ST_SH_IR)      tdo <= ir_so;
            else if (state == ST_SH_DR) tdo <= dr_so;
        end
    end

    assert_tdo_en_window_R5: assert property (@(posedge tck) disable iff (tap_rst)
        tdo_en == ((state == ST_SH_DR) || (state == ST_SH_IR)));

    assert_bist_launch_R13: assert property (@(posedge tck) disable iff (tap_rst)
        $rose(bist_start) |-> $past(state) == ST_UPD_IR);

endmodule

// File: tb/tap_bist_ctrl_tb.sv
module tap_bist_ctrl_tb;

    localparam logic [31:0] IDV = 32'h1A5B_C0DF;

    logic tck = 1'b0;
    always #4 tck = ~tck;

    logic       tap_rst = 1'b1, tms = 1'b1, tdi = 1'b0;
    logic [1:0] pin_in = '0, core_out = '0;
    logic       pin_bi_i = 1'b0, core_bi_o = 1'b0, core_oe = 1'b0, pin_obs = 1'b0;
    logic       bist_done = 1'b0, bist_pass = 1'b0;
    logic       tdo, tdo_en, pin_bi_o, core_bi_i, pin_oe, bist_start;
    logic [1:0] core_in, pin_out;
    logic       tdo2, tdo_en2, pin_bi_o2, core_bi_i2, pin_oe2, bist_start2;
    logic [1:0] core_in2, pin_out2;

    tap_bist_ctrl #(.ID_VALUE(IDV)) u_dut (
        .tck(tck), .tap_rst(tap_rst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .pin_in(pin_in), .core_in(core_in), .pin_bi_i(pin_bi_i), .pin_bi_o(pin_bi_o),
        .core_bi_o(core_bi_o), .core_bi_i(core_bi_i), .core_out(core_out), .pin_out(pin_out),
        .core_oe(core_oe), .pin_oe(pin_oe), .pin_obs(pin_obs), .bist_start(bist_start),
        .bist_done(bist_done), .bist_pass(bist_pass));

    tap_bist_ctrl #(.HAS_ID(1'b0)) u_dut_noid (
        .tck(tck), .tap_rst(tap_rst), .tms(tms), .tdi(tdi), .tdo(tdo2), .tdo_en(tdo_en2),
        .pin_in(pin_in), .core_in(core_in2), .pin_bi_i(pin_bi_i), .pin_bi_o(pin_bi_o2),
        .core_bi_o(core_bi_o), .core_bi_i(core_bi_i2), .core_out(core_out), .pin_out(pin_out2),
        .core_oe(core_oe), .pin_oe(pin_oe2), .pin_obs(pin_obs), .bist_start(bist_start2),
        .bist_done(bist_done), .bist_pass(bist_pass));

    typedef struct {
        logic [63:0] v;
        int          n;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [63:0] obs_q[$];
    event        obs_ev;
    int          errors = 0;
    int          checks = 0;

    task automatic chk(input logic [63:0] act, input logic [63:0] expv, input string tag);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic drain();
        while (obs_q.size() > 0 && exp_q.size() > 0) begin
            exp_t        e;
            logic [63:0] o, mask;
            e    = exp_q.pop_front();
            o    = obs_q.pop_front();
            mask = (e.n >= 64) ? '1 : ((64'd1 << e.n) - 64'd1);
            chk(o & mask, e.v & mask, e.tag);
        end
    endtask

    // monitor: compares observed scans against queued expectations
    initial forever begin
        @(obs_ev);
        drain();
    end

    task automatic step(input logic m, input logic d, output logic s, output logic s2, output logic en);
        @(negedge tck);
        #1;
        s   = tdo;
        s2  = tdo2;
        en  = tdo_en;
        tms = m;
        tdi = d;
        @(posedge tck);
    endtask

    task automatic nav(input logic m);
        logic a, b, c;
        step(m, 1'b0, a, b, c);
    endtask

    // starts and ends in Run-Test/Idle
    task automatic scan(input bit is_ir, input int n, input logic [63:0] din,
                        input logic [63:0] expv, input string tag,
                        output logic [63:0] dout, output logic [63:0] dout2);
        logic s, s2, en;
        if (tag != "") exp_q.push_back('{expv, n, tag});
        nav(1'b1);
        if (is_ir) nav(1'b1);
        nav(1'b0);
        nav(1'b0);
        dout  = '0;
        dout2 = '0;
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], s, s2, en);
            dout[i]  = s;
            dout2[i] = s2;
            if (i == 0) chk({63'd0, en}, 64'd1, "R5 tdo_en high in shift");
        end
        nav(1'b1);
        nav(1'b0);
        if (tag != "") begin
            obs_q.push_back(dout);
            -> obs_ev;
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [63:0] o, o2;
        logic [6:0]  pre;
        pre = 7'b0110001;

        repeat (3) @(posedge tck);
        @(negedge tck);
        tap_rst = 1'b0;
        core_out = 2'b01; pin_in = 2'b10; pin_bi_i = 1'b1; core_bi_o = 1'b1;
        nav(1'b0);
        #1;
        chk({63'd0, tdo_en}, 64'd0, "R5 tdo_en low after reset");
        chk({62'd0, pin_out}, {62'd0, core_out}, "R3 pin_out transparent");
        chk({62'd0, core_in}, {62'd0, pin_in}, "R3 core_in transparent");
        chk({63'd0, pin_bi_o}, {63'd0, core_bi_o}, "R3 bidir transparent");

        // reset instruction: IDCODE, or pass-through without ID register
        scan(1'b0, 32, 64'h0000_00A5, {32'd0, IDV}, "R8 R1 R3 idcode after reset", o, o2);
        chk(o2 & 64'hFFFF_FFFF, {31'd0, 32'h0000_00A5, 1'b0} & 64'hFFFF_FFFF, "R3 no-id selects bypass");

        // capture value of the instruction register, flags low
        scan(1'b1, 4, 64'hF, 64'b0001, "R4 ir capture", o, o2);
        #1 chk({63'd0, tdo_en}, 64'd0, "R5 tdo_en low in idle");
        scan(1'b0, 8, 64'hB4, 64'h68, "R7 bypass delay", o, o2);

        scan(1'b1, 4, 64'hA, 64'd0, "", o, o2);
        scan(1'b0, 4, 64'hB, 64'h6, "R6 unknown code bypass", o, o2);

        // five TMS-high clocks return to reset
        scan(1'b1, 4, 64'hF, 64'd0, "", o, o2);
        repeat (5) nav(1'b1);
        nav(1'b0);
        scan(1'b0, 32, 64'd0, {32'd0, IDV}, "R2 five tms high", o, o2);

        scan(1'b1, 4, 64'hF, 64'd0, "", o, o2);
        @(negedge tck) tap_rst = 1'b1;
        @(posedge tck);
        @(negedge tck) tap_rst = 1'b0;
        nav(1'b0);
        scan(1'b0, 32, 64'd0, {32'd0, IDV}, "R2 tap_rst", o, o2);

        // SAMPLE/PRELOAD
        @(negedge tck);
        core_oe = 1'b0; pin_obs = 1'b1;
        scan(1'b1, 4, 64'h1, 64'd0, "", o, o2);
        scan(1'b0, 7, {57'd0, pre}, 64'b1001110, "R9 R12 sample capture order", o, o2);
        #1;
        chk({62'd0, pin_out}, 64'b01, "R12 pins unchanged by preload");
        chk({63'd0, pin_oe}, 64'd0, "R12 oe unchanged by preload");
        chk({63'd0, pin_bi_o}, 64'd1, "R12 bidir unchanged by preload");

        // EXTEST
        scan(1'b1, 4, 64'h0, 64'd0, "", o, o2);
        #1;
        chk({62'd0, pin_out}, 64'b10, "R10 extest pin_out");
        chk({63'd0, pin_oe}, 64'd1, "R10 extest pin_oe");
        chk({63'd0, pin_bi_o}, 64'd0, "R10 extest bidir");
        chk({62'd0, core_in}, 64'b10, "R10 core sees pads");
        @(negedge tck) pin_in = 2'b01;
        scan(1'b0, 7, {57'd0, pre}, 64'b1001101, "R10 R9 extest capture", o, o2);

        // INTEST
        @(negedge tck) pin_in = 2'b10;
        scan(1'b1, 4, 64'h3, 64'd0, "", o, o2);
        #1;
        chk({62'd0, core_in}, 64'b01, "R11 core_in from update");
        chk({63'd0, core_bi_i}, 64'd0, "R11 core_bi_i from update");
        chk({62'd0, pin_out}, 64'b10, "R11 pads held");

        // RUNBIST
        scan(1'b1, 4, 64'h4, 64'b0001, "R4 capture before bist", o, o2);
        #1 chk({63'd0, bist_start}, 64'd1, "R13 bist_start after update");
        @(negedge tck) bist_done = 1'b1;
        repeat (4) nav(1'b0);
        scan(1'b0, 2, 64'd0, 64'b01, "R13 result done only", o, o2);
        @(negedge tck) bist_pass = 1'b1;
        repeat (4) nav(1'b0);
        scan(1'b0, 2, 64'd0, 64'b11, "R13 result done and pass", o, o2);
        #1 chk({63'd0, bist_start}, 64'd1, "R13 bist_start held");
        scan(1'b1, 4, 64'hF, 64'b1101, "R4 status bits", o, o2);
        #1 chk({63'd0, bist_start}, 64'd0, "R13 bist_start dropped");

        #20;
        drain();
        if (exp_q.size() != 0) chk(64'(exp_q.size()), 64'd0, "scoreboard leftover");
        summary();
    end

endmodule